// File: doc/BRIEF.md
# Completion Queue Entry Poster

This block turns finished requests into completion records and writes them into a circular ring kept in host memory. Requests wait in an upstream FIFO with a valid/ready handshake. Each one carries a command tag, a 15-bit status code, the number of the submission queue it came from and that queue's current head index. The poster keeps the ring's producer index (tail) and a phase tag. It gets the consumer index (head) from the host through a strobed input. It builds one 128-bit record per request, works out the slot address and issues a memory write. It holds the write steady until the fabric accepts it.

Posting happens in passes. A pass starts a fixed number of cycles after work is seen waiting while the ring has space. Inside a pass, records go out back to back until the FIFO is empty or the ring fills. The pass then closes with a one-cycle interrupt pulse. The pulse goes to the queue's message vector when message interrupts are on, or to the line interrupt otherwise. No pulse is sent when interrupts are disabled for the queue.

The phase tag flips each time the tail wraps. Because it sits in bit 0 of the status halfword, the host can tell fresh records from stale ones by inspecting the ring alone.

Top module: `cqp_poster`

## Requirements
- R1: After reset, and one cycle after a `cfg_create` pulse, tail and head are 0 and the phase tag is 1, so the first record goes to `cfg_base` with phase bit 1. While in reset, `wr_valid`, `pend_ready` and both interrupt pulses are 0.
- R2: The tail advances by one for each record taken from the FIFO. On reaching `cfg_size_m1 + 1` it returns to 0 and the phase tag inverts.
- R3: The ring counts as full when (tail + 1) modulo (`cfg_size_m1` + 1) equals head. While full, `pend_ready` stays 0 and pending requests remain in the FIFO.
- R4: Bits [127:112] of `wr_data` hold the status code in [127:113] and the phase tag at the time of posting in bit 112.
- R5: Bits [111:96] of `wr_data` hold the command tag, [95:80] the submission queue number, [79:64] that queue's head value, and [63:0] are zero.
- R6: `head_val` is taken only on a `head_upd` strobe. A value above `cfg_size_m1` is ignored and the head keeps its old value.
- R7: `wr_addr` equals `cfg_base` + (tail << `cfg_esz_exp`), using the tail before it advances. The default exponent of 4 gives 16-byte slots.
- R8: When the poster is idle and sees `pend_valid` with room in the ring, it waits DELAY cycles and then begins a pass. Within a pass, a request is popped only after the previous write has been accepted.
- R9: Once `wr_valid` is high it stays high, with `wr_addr` and `wr_data` unchanged, until `wr_ready` is seen.
- R10: One cycle after a pass finds no more work, a single-cycle pulse is issued. If `cfg_irq_en` and `cfg_msix_en` are both set, `msix_pulse` fires with `msix_vector` = `cfg_vector`. If `cfg_irq_en` is set and `cfg_msix_en` is clear, `intx_pulse` fires. If `cfg_irq_en` is clear, neither fires. `msix_vector` is 0 whenever `msix_pulse` is low.
- R11: A head update that frees space in a full ring with requests waiting starts a new pass after DELAY cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_create | input | 1 | Queue creation pulse: clears the indices and sets phase to 1 |
| cfg_size_m1 | input | 11 | Ring size minus one |
| cfg_base | input | 64 | Ring base address in host memory |
| cfg_esz_exp | input | 4 | log2 of the record size in bytes |
| cfg_irq_en | input | 1 | Interrupts enabled for this queue |
| cfg_msix_en | input | 1 | Use message interrupts instead of the line interrupt |
| cfg_vector | input | 6 | Message interrupt vector of this queue |
| head_upd | input | 1 | Host head update strobe |
| head_val | input | 11 | New head index |
| pend_valid | input | 1 | Pending FIFO has a request |
| pend_ready | output | 1 | Pop the pending FIFO |
| pend_cid | input | 16 | Command tag |
| pend_status | input | 15 | Completion status code |
| pend_sqid | input | 16 | Submission queue number |
| pend_sqhead | input | 16 | Submission queue head value |
| wr_valid | output | 1 | Memory write request valid |
| wr_ready | input | 1 | Memory write accepted |
| wr_addr | output | 64 | Write address |
| wr_data | output | 128 | Completion record |
| msix_pulse | output | 1 | Message interrupt pulse |
| msix_vector | output | 6 | Vector for the message interrupt |
| intx_pulse | output | 1 | Line interrupt pulse |

## Verification
The bench aims at the wrap, using rings of two, four and eight slots. A design that flips the phase at the wrong index, or never flips it, writes a wrong bit 112 on the first record after the wrap. It also aims at the full boundary. A design off by one in its full test either overwrites the slot the host has not yet consumed or leaves one slot unused, and `pend_ready` then differs from the model's in that cycle. Head values above the ring size are written while requests are blocked; a design that takes such a value would start posting when it should stay stalled. Random `wr_ready` back-pressure, different slot exponents and all three interrupt settings show whether the record is held until accepted, whether it lands at the right address, and whether the right pulse, or none, closes each pass.

// File: rtl/cqp_pkg.sv
`timescale 1ns/1ps
package cqp_pkg;

    localparam int CQP_ENTRY_W = 128;

    typedef struct packed {
        logic [15:0] cid;
        logic [14:0] status;
        logic [15:0] sqid;
        logic [15:0] sqhead;
    } cpl_req_t;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_WAIT,
        SEQ_LOAD,
        SEQ_WRITE,
        SEQ_NOTIFY
    } seq_state_e;

    // Record layout: status/phase halfword on top, result dwords zero.
    function automatic logic [CQP_ENTRY_W-1:0] form_entry(cpl_req_t r, logic phase);
        return {r.status, phase, r.cid, r.sqid, r.sqhead, 64'd0};
    endfunction

endpackage

// File: rtl/cqp_ring.sv
`timescale 1ns/1ps
module cqp_ring #(
    parameter int QW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          create,
    input  logic [QW-1:0] size_m1,
    input  logic          head_upd,
    input  logic [QW-1:0] head_val,
    input  logic          advance,
    output logic [QW-1:0] tail,
    output logic [QW-1:0] head,
    output logic          phase,
    output logic          full
);
    logic          at_end;
    logic [QW-1:0] tail_inc;

    always_comb begin
        at_end   = (tail == size_m1);
        tail_inc = at_end ? '0 : QW'(tail + 1'b1);
        full     = (tail_inc == head);
    end

    always_ff @(posedge clk) begin
        if (rst || create) begin
            tail  <= '0;
            head  <= '0;
            phase <= 1'b1;
        end else begin
            if (head_upd && (head_val <= size_m1)) begin
                head <= head_val;
            end
            if (advance) begin
                tail <= tail_inc;
                if (at_end) begin
                    phase <= ~phase;
                end
            end
        end
    end
endmodule

// File: rtl/cqp_seq.sv
`timescale 1ns/1ps
module cqp_seq
    import cqp_pkg::*;
#(
    parameter int DELAY = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pend_valid,
    input  logic ring_full,
    input  logic wr_ready,
    output logic load,
    output logic wr_valid,
    output logic notify
);
    localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;

    seq_state_e    state;
    logic [CW-1:0] cnt;

    always_comb begin
        load     = (state == SEQ_LOAD) && pend_valid && !ring_full;
        wr_valid = (state == SEQ_WRITE);
        notify   = (state == SEQ_NOTIFY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (pend_valid && !ring_full) begin
                        state <= SEQ_WAIT;
                        cnt   <= '0;
                    end
                end
                SEQ_WAIT: begin
                    if (cnt == CW'(DELAY - 1)) begin
                        state <= SEQ_LOAD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_LOAD: state <= load ? SEQ_WRITE : SEQ_NOTIFY;
                SEQ_WRITE: begin
                    if (wr_ready) begin
                        state <= SEQ_LOAD;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cqp_irq.sv
`timescale 1ns/1ps
module cqp_irq #(
    parameter int VW = 6
) (
    input  logic          notify,
    input  logic          irq_en,
    input  logic          msix_en,
    input  logic [VW-1:0] vector,
    output logic          msix_pulse,
    output logic [VW-1:0] msix_vector,
    output logic          intx_pulse
);
    always_comb begin
        msix_pulse  = notify && irq_en && msix_en;
        intx_pulse  = notify && irq_en && !msix_en;
        msix_vector = msix_pulse ? vector : '0;
    end
endmodule

// File: rtl/cqp_poster.sv
`timescale 1ns/1ps
module cqp_poster
    import cqp_pkg::*;
#(
    parameter int MAX_ENTRIES = 2048,
    parameter int DELAY       = 8,
    parameter int VW          = 6,
    parameter int AW          = 64,
    parameter int EXPW        = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_create,
    input  logic [$clog2(MAX_ENTRIES)-1:0] cfg_size_m1,
    input  logic [AW-1:0]          cfg_base,
    input  logic [EXPW-1:0]        cfg_esz_exp,
    input  logic                   cfg_irq_en,
    input  logic                   cfg_msix_en,
    input  logic [VW-1:0]          cfg_vector,
    input  logic                   head_upd,
    input  logic [$clog2(MAX_ENTRIES)-1:0] head_val,
    input  logic                   pend_valid,
    output logic                   pend_ready,
    input  logic [15:0]            pend_cid,
    input  logic [14:0]            pend_status,
    input  logic [15:0]            pend_sqid,
    input  logic [15:0]            pend_sqhead,
    output logic                   wr_valid,
    input  logic                   wr_ready,
    output logic [AW-1:0]          wr_addr,
    output logic [CQP_ENTRY_W-1:0] wr_data,
    output logic                   msix_pulse,
    output logic [VW-1:0]          msix_vector,
    output logic                   intx_pulse
);
    localparam int QW = $clog2(MAX_ENTRIES);

    logic [QW-1:0] ring_tail;
    logic [QW-1:0] ring_head;
    logic          ring_phase;
    logic          ring_full;
    logic          load;
    logic          notify;
    cpl_req_t      req;

    always_comb begin
        req.cid    = pend_cid;
        req.status = pend_status;
        req.sqid   = pend_sqid;
        req.sqhead = pend_sqhead;
        pend_ready = load;
    end

    cqp_ring #(.QW(QW)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .create   (cfg_create),
        .size_m1  (cfg_size_m1),
        .head_upd (head_upd),
        .head_val (head_val),
        .advance  (load),
        .tail     (ring_tail),
        .head     (ring_head),
        .phase    (ring_phase),
        .full     (ring_full)
    );

    cqp_seq #(.DELAY(DELAY)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pend_valid (pend_valid),
        .ring_full  (ring_full),
        .wr_ready   (wr_ready),
        .load       (load),
        .wr_valid   (wr_valid),
        .notify     (notify)
    );

    cqp_irq #(.VW(VW)) u_irq (
        .notify      (notify),
        .irq_en      (cfg_irq_en),
        .msix_en     (cfg_msix_en),
        .vector      (cfg_vector),
        .msix_pulse  (msix_pulse),
        .msix_vector (msix_vector),
        .intx_pulse  (intx_pulse)
    );

    // Record and address are captured when the request is popped and held
    // until the write is accepted.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (load) begin
            wr_addr <= cfg_base + (AW'(ring_tail) << cfg_esz_exp);
            wr_data <= form_entry(req, ring_phase);
        end
    end
endmodule

// File: rtl/cqp_poster_chk.sv
`timescale 1ns/1ps
module cqp_poster_chk #(
    parameter int QW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_create,
    input logic [QW-1:0] cfg_size_m1,
    input logic          head_upd,
    input logic [QW-1:0] head_val,
    input logic          pend_ready,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [63:0]   wr_addr,
    input logic [127:0]  wr_data,
    input logic          msix_pulse,
    input logic          intx_pulse,
    input logic          ring_full,
    input logic [QW-1:0] ring_head,
    input logic [QW-1:0] ring_tail,
    input logic          ring_phase
);
    assert_create_clears_R1: assert property (@(posedge clk) disable iff (rst)
        cfg_create |=> (ring_tail == '0) && (ring_head == '0) && ring_phase);

    assert_phase_at_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_create) && (ring_phase != $past(ring_phase))) |-> (ring_tail == '0));

    assert_no_pop_when_full_R3: assert property (@(posedge clk) disable iff (rst)
        ring_full |-> !pend_ready);

    assert_bad_head_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (head_upd && !cfg_create && (head_val > cfg_size_m1)) |=> $stable(ring_head));

    assert_write_held_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (msix_pulse || intx_pulse) |=> !(msix_pulse || intx_pulse));
endmodule

bind cqp_poster cqp_poster_chk #(.QW(QW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_create  (cfg_create),
    .cfg_size_m1 (cfg_size_m1),
    .head_upd    (head_upd),
    .head_val    (head_val),
    .pend_ready  (pend_ready),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .msix_pulse  (msix_pulse),
    .intx_pulse  (intx_pulse),
    .ring_full   (ring_full),
    .ring_head   (ring_head),
    .ring_tail   (ring_tail),
    .ring_phase  (ring_phase)
);

// File: tb/cqp_poster_test.sv
`timescale 1ns/1ps
module cqp_poster_test;
    localparam int DELAY = 8;

    typedef struct packed {
        logic [15:0] cid;
        logic [14:0] status;
        logic [15:0] sqid;
        logic [15:0] sqhead;
    } tb_req_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_create = 1'b0;
    logic [10:0]  cfg_size_m1 = 11'd3;
    logic [63:0]  cfg_base = 64'd0;
    logic [3:0]   cfg_esz_exp = 4'd4;
    logic         cfg_irq_en = 1'b1;
    logic         cfg_msix_en = 1'b1;
    logic [5:0]   cfg_vector = 6'd0;
    logic         head_upd = 1'b0;
    logic [10:0]  head_val = 11'd0;
    logic         pend_valid = 1'b0;
    logic         pend_ready;
    logic [15:0]  pend_cid = 16'd0;
    logic [14:0]  pend_status = 15'd0;
    logic [15:0]  pend_sqid = 16'd0;
    logic [15:0]  pend_sqhead = 16'd0;
    logic         wr_valid;
    logic         wr_ready = 1'b1;
    logic [63:0]  wr_addr;
    logic [127:0] wr_data;
    logic         msix_pulse;
    logic [5:0]   msix_vector;
    logic         intx_pulse;

    always #2 clk = ~clk;

    cqp_poster #(.DELAY(DELAY)) uut (
        .clk(clk), .rst(rst), .cfg_create(cfg_create), .cfg_size_m1(cfg_size_m1),
        .cfg_base(cfg_base), .cfg_esz_exp(cfg_esz_exp), .cfg_irq_en(cfg_irq_en),
        .cfg_msix_en(cfg_msix_en), .cfg_vector(cfg_vector), .head_upd(head_upd),
        .head_val(head_val), .pend_valid(pend_valid), .pend_ready(pend_ready),
        .pend_cid(pend_cid), .pend_status(pend_status), .pend_sqid(pend_sqid),
        .pend_sqhead(pend_sqhead), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .msix_pulse(msix_pulse),
        .msix_vector(msix_vector), .intx_pulse(intx_pulse)
    );

    // stimulus state
    tb_req_t     pq[$];
    logic        nx_create = 1'b0;
    logic        nx_hupd = 1'b0;
    logic [10:0] nx_hval = 11'd0;
    bit          stall_mode = 1'b0;

    // reference model state
    int           m_st = 0;
    int           m_cnt = 0;
    int           m_tail = 0;
    int           m_head = 0;
    logic         m_phase = 1'b1;
    logic [63:0]  m_addr = '0;
    logic [127:0] m_data = '0;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    int posted = 0;

    task automatic cmp(string req, string what, logic [127:0] act, logic [127:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    task automatic tick();
        int   nxt;
        logic mfull;
        logic e_pr, e_wv, e_msix, e_intx;
        @(negedge clk);
        if (pq.size() > 0) begin
            pend_valid  = 1'b1;
            pend_cid    = pq[0].cid;
            pend_status = pq[0].status;
            pend_sqid   = pq[0].sqid;
            pend_sqhead = pq[0].sqhead;
        end else begin
            pend_valid  = 1'b0;
            pend_cid    = '0;
            pend_status = '0;
            pend_sqid   = '0;
            pend_sqhead = '0;
        end
        wr_ready   = stall_mode ? 1'($urandom_range(0, 1)) : 1'b1;
        cfg_create = nx_create;
        head_upd   = nx_hupd;
        head_val   = nx_hval;
        nx_create  = 1'b0;
        nx_hupd    = 1'b0;
        #1;
        nxt    = (m_tail == int'(cfg_size_m1)) ? 0 : m_tail + 1;
        mfull  = (nxt == m_head);
        e_pr   = !rst && (m_st == 2) && pend_valid && !mfull;
        e_wv   = !rst && (m_st == 3);
        e_msix = !rst && (m_st == 4) && cfg_irq_en && cfg_msix_en;
        e_intx = !rst && (m_st == 4) && cfg_irq_en && !cfg_msix_en;
        cmp("R3 R8 R11", "pend_ready", 128'(pend_ready), 128'(e_pr));
        cmp("R8 R9", "wr_valid", 128'(wr_valid), 128'(e_wv));
        cmp("R10", "msix_pulse", 128'(msix_pulse), 128'(e_msix));
        cmp("R10", "intx_pulse", 128'(intx_pulse), 128'(e_intx));
        cmp("R10", "msix_vector", 128'(msix_vector), e_msix ? 128'(cfg_vector) : 128'd0);
        if (e_wv) begin
            cmp("R1 R7", "wr_addr", 128'(wr_addr), 128'(m_addr));
            cmp("R2 R4", "status/phase", 128'(wr_data[127:112]), 128'(m_data[127:112]));
            cmp("R5", "tag/queue/head", 128'(wr_data[111:64]), 128'(m_data[111:64]));
            cmp("R5", "low dwords", 128'(wr_data[63:0]), 128'd0);
            if (wr_ready) posted++;
        end
        // model step
        if (rst) begin
            m_st = 0; m_cnt = 0; m_tail = 0; m_head = 0; m_phase = 1'b1;
        end else begin
            case (m_st)
                0: if (pend_valid && !mfull) begin m_st = 1; m_cnt = 0; end
                1: if (m_cnt == DELAY - 1) m_st = 2; else m_cnt++;
                2: begin
                    if (e_pr) begin
                        m_addr = cfg_base + (64'(m_tail) << cfg_esz_exp);
                        m_data = {pend_status, m_phase, pend_cid, pend_sqid, pend_sqhead, 64'd0};
                        m_st = 3;
                    end else begin
                        m_st = 4;
                    end
                end
                3: if (wr_ready) m_st = 2;
                default: m_st = 0;
            endcase
            if (cfg_create) begin
                m_tail = 0; m_head = 0; m_phase = 1'b1;
            end else begin
                if (head_upd && (int'(head_val) <= int'(cfg_size_m1))) m_head = int'(head_val);
                if (e_pr) begin
                    if (m_tail == int'(cfg_size_m1)) begin
                        m_tail = 0; m_phase = ~m_phase;
                    end else begin
                        m_tail++;
                    end
                end
            end
        end
        if (e_pr) void'(pq.pop_front());
        cycles++;
        if (cycles > 50000) begin
            mismatched++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_run();
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic push(int cid, int sts);
        tb_req_t r;
        r.cid    = 16'(cid);
        r.status = 15'(sts);
        r.sqid   = 16'(cid * 3 + 1);
        r.sqhead = 16'(cid ^ 16'h00a5);
        pq.push_back(r);
    endtask

    task automatic host_head(int v);
        nx_hupd = 1'b1;
        nx_hval = 11'(v);
        tick();
    endtask

    task automatic recreate(int size_m1, logic [63:0] base, int ex);
        cfg_size_m1 = 11'(size_m1);
        cfg_base    = base;
        cfg_esz_exp = 4'(ex);
        nx_create   = 1'b1;
        tick();
    endtask

    initial begin
        cfg_vector = 6'd5;
        run(4);
        // R1: quiet outputs during reset
        cmp("R1", "reset wr_valid", 128'(wr_valid), 128'd0);
        cmp("R1", "reset pend_ready", 128'(pend_ready), 128'd0);
        rst = 1'b0;
        recreate(3, 64'h0000_0001_0000_1000, 4);

        // three records fill a four-slot ring, two more stay pending (R3)
        for (int i = 0; i < 3; i++) push(10 + i, 2 * i + 1);
        run(40);
        for (int i = 0; i < 2; i++) push(20 + i, 7);
        run(40);
        cmp("R3", "posted before full", 128'(posted), 128'd3);
        cmp("R3", "requests held while full", 128'(pq.size()), 128'd2);

        // head frees space: wrap and phase flip (R2, R11)
        host_head(2);
        run(40);
        cmp("R11", "posted after head update", 128'(posted), 128'd5);

        // out-of-range head ignored while blocked (R6)
        push(30, 9);
        host_head(7);
        run(30);
        cmp("R6", "bad head leaves request pending", 128'(pq.size()), 128'd1);
        host_head(1);
        run(30);
        cmp("R6", "valid head releases request", 128'(pq.size()), 128'd0);

        // line interrupt, larger slot, back-pressure (R7, R9, R10)
        cfg_msix_en = 1'b0;
        stall_mode  = 1'b1;
        recreate(7, 64'h0000_0000_8000_0000, 5);
        for (int i = 0; i < 6; i++) push(40 + i, 100 + i);
        run(80);
        host_head(6);
        for (int i = 0; i < 5; i++) push(50 + i, 200 + i);
        run(80);

        // interrupts off (R10)
        cfg_irq_en = 1'b0;
        host_head(3);
        push(60, 1);
        push(61, 2);
        run(40);

        // two-slot ring, repeated fill/free (R2, R3, R11)
        cfg_irq_en  = 1'b1;
        cfg_msix_en = 1'b1;
        cfg_vector  = 6'd33;
        recreate(1, 64'h0000_0000_0004_0000, 4);
        for (int i = 0; i < 6; i++) push(70 + i, 300 + i);
        for (int k = 0; k < 6; k++) begin
            run(30);
            host_head((k + 1) % 2);
        end
        run(40);
        cmp("R3", "two-slot ring drained", 128'(pq.size()), 128'd0);

        finish_run();
    end
endmodule